// File: doc/BRIEF.md
# Timer Channel Count Latch and Status Readback

This block is the host read path of one interval-timer channel. The host writes command bytes to a control register that all channels share, and it reads the channel's data port one byte at a time. The block watches those command bytes for the ones aimed at its own channel. It keeps a copy of the channel's programmed access fields. When asked, it takes a snapshot of the live 16-bit down-count, so that the low and high bytes read afterwards belong to one value even though the counter keeps moving.

On a read-back command it also captures a status byte. That byte carries the current output level, the null-count flag and the six low bits of the channel's last control word. A pending status byte is always returned first, and any latched count bytes follow it.

The counting element and its output logic sit outside this block. They supply the live count, the output level and the null-count flag.

Top module: `tmr_readback`

## Requirements
- R1: After reset, rd_data is 0, no count or status snapshot is pending, the access mode is low-then-high and the byte pointer selects the low byte.
- R2: A command byte with bits 7:6 equal to the parameter CHAN and bits 5:4 nonzero is a control word for this channel. It stores bits 5:0 as the control echo and bits 5:4 as the access mode (01 low only, 10 high only, 11 low then high). It drops any pending count or status snapshot and returns the byte pointer to the low byte.
- R3: A command byte with bits 7:6 equal to CHAN and bits 5:4 equal to 00 captures the live count in that clock cycle. Later reads return bytes of the captured value.
- R4: Count-capture requests that arrive while a count snapshot is pending leave the held value unchanged.
- R5: A count snapshot is released after one read in low-only or high-only mode, and after the high-byte read in low-then-high mode. Reads after that return live-count bytes.
- R6: In low-then-high mode, count reads alternate low byte then high byte. Low-only mode always returns bits 7:0, and high-only mode always returns bits 15:8.
- R7: A command byte with bits 7:6 equal to 11 is a read-back command for every channel whose mask bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2. Bit 5 at 0 requests a count capture, and bit 4 at 0 requests a status capture.
- R8: The status byte is captured when it is requested. Bit 7 is the output level, bit 6 is the null-count flag, and bits 5:0 are the stored control echo.
- R9: When a status byte and a count snapshot are both pending, the first read returns the status byte. That read does not advance the byte pointer, and the count bytes follow it.
- R10: A status request while a status byte is pending is ignored. The pending status byte is released by the one read that returns it.
- R11: Control words, capture commands and read-back commands that do not select this channel change neither the snapshots nor the pointer.
- R12: rd_data is registered. It shows the selected byte in the cycle after the read strobe and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_wr | input | 1 | Strobe for a write to the shared control register |
| cw_data | input | 8 | Command byte written to the control register |
| rd | input | 1 | Strobe for a read of this channel's data port |
| live_count | input | 16 | Current count of the counting element |
| out_level | input | 1 | Current level of the channel output |
| null_count | input | 1 | High while a new count awaits transfer into the counting element |
| rd_data | output | 8 | Registered read byte |

## Verification
A byte pointer in the wrong position swaps the low and high bytes on the very next read, so the fault shows one cycle after the strobe. A snapshot that releases too early or too late shows up on the read after the last expected byte: that read returns a live byte where a held one was due, or the reverse. A status flag that is stuck or not cleared either replaces a count byte with a status byte, or lets count bytes appear where the status byte should come first. The running live count in the bench makes every such slip visible as a mismatched value.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
  typedef enum logic [1:0] {
    ACC_CMD = 2'b00,
    ACC_LO  = 2'b01,
    ACC_HI  = 2'b10,
    ACC_LH  = 2'b11
  } acc_e;

  localparam logic [1:0] SEL_RB = 2'b11;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_rb_pkg::*;
#(
  parameter int CHAN = 0
) (
  input  logic       cw_wr,
  input  logic [7:1] cmd,
  output logic       prog_hit,
  output logic       cnt_req,
  output logic       st_req
);
  localparam logic [1:0] MY_SEL = 2'(CHAN);
  localparam int MASK_BIT = 1 + CHAN;

  logic       is_mine;
  logic       is_rb;
  logic       rb_hit;
  logic [1:0] acc;

  always_comb begin
    is_mine  = (cmd[7:6] == MY_SEL);
    is_rb    = (cmd[7:6] == SEL_RB);
    acc      = cmd[5:4];
    rb_hit   = is_rb && cmd[MASK_BIT];
    prog_hit = cw_wr && is_mine && (acc != ACC_CMD);
    cnt_req  = cw_wr && ((is_mine && acc == ACC_CMD) || (rb_hit && !cmd[5]));
    st_req   = cw_wr && rb_hit && !cmd[4];
  end
endmodule

// File: rtl/tmr_hold_reg.sv
module tmr_hold_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         capture,
  input  logic         release_i,
  input  logic [W-1:0] din,
  output logic [W-1:0] hold,
  output logic         pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      pend <= 1'b0;
    end else if (clear || release_i) begin
      pend <= 1'b0;
    end else if (capture && !pend) begin
      hold <= din;
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_byte_seq.sv
module tmr_byte_seq
  import tmr_rb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd,
  input  logic                  prog,
  input  acc_e                  acc,
  input  logic                  st_pend,
  input  logic [DATA_W-1:0]     st_val,
  input  logic [2*DATA_W-1:0]   cnt_val,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  cnt_done,
  output logic                  ptr
);
  localparam int NBYTE = 2;

  logic [DATA_W-1:0] bytes [NBYTE];
  logic [DATA_W-1:0] cnt_byte;

  for (genvar i = 0; i < NBYTE; i++) begin : g_split
    assign bytes[i] = cnt_val[i*DATA_W +: DATA_W];
  end

  always_comb begin
    unique case (acc)
      ACC_LO:  cnt_byte = bytes[0];
      ACC_HI:  cnt_byte = bytes[1];
      default: cnt_byte = bytes[ptr];
    endcase
    cnt_done = rd && !st_pend && ((acc != ACC_LH) || ptr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      ptr     <= 1'b0;
    end else begin
      if (rd) begin
        if (st_pend) begin
          rd_data <= st_val;
        end else begin
          rd_data <= cnt_byte;
          if (acc == ACC_LH) ptr <= ~ptr;
        end
      end
      if (prog) ptr <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback
  import tmr_rb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN   = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cw_wr,
  input  logic [DATA_W-1:0]   cw_data,
  input  logic                rd,
  input  logic [2*DATA_W-1:0] live_count,
  input  logic                out_level,
  input  logic                null_count,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int CTRL_W = DATA_W - 2;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'({ACC_LH, 4'b0000});

  logic                prog_hit, cnt_req, st_req;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                cnt_pend, st_pend, cnt_done, ptr;
  logic [CNT_W-1:0]    cnt_hold, cnt_sel;
  logic [DATA_W-1:0]   st_now, st_hold;
  logic                st_rel;
  acc_e                acc;

  tmr_cmd_decode #(.CHAN(CHAN)) u_dec (
    .cw_wr    (cw_wr),
    .cmd      (cw_data[7:1]),
    .prog_hit (prog_hit),
    .cnt_req  (cnt_req),
    .st_req   (st_req)
  );

  always_ff @(posedge clk) begin
    if (rst)           ctrl_q <= CTRL_RST;
    else if (prog_hit) ctrl_q <= cw_data[CTRL_W-1:0];
  end

  assign acc    = acc_e'(ctrl_q[5:4]);
  assign st_now = {out_level, null_count, ctrl_q};
  assign st_rel = rd && st_pend;

  tmr_hold_reg #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clear     (prog_hit),
    .capture   (cnt_req),
    .release_i (cnt_done && cnt_pend),
    .din       (live_count),
    .hold      (cnt_hold),
    .pend      (cnt_pend)
  );

  tmr_hold_reg #(.W(DATA_W)) u_st (
    .clk       (clk),
    .rst       (rst),
    .clear     (prog_hit),
    .capture   (st_req),
    .release_i (st_rel),
    .din       (st_now),
    .hold      (st_hold),
    .pend      (st_pend)
  );

  assign cnt_sel = cnt_pend ? cnt_hold : live_count;

  tmr_byte_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rd       (rd),
    .prog     (prog_hit),
    .acc      (acc),
    .st_pend  (st_pend),
    .st_val   (st_hold),
    .cnt_val  (cnt_sel),
    .rd_data  (rd_data),
    .cnt_done (cnt_done),
    .ptr      (ptr)
  );
endmodule

// File: rtl/tmr_readback_chk.sv
module tmr_readback_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                rd,
  input logic [DATA_W-1:0]   rd_data,
  input logic                out_level,
  input logic                prog_hit,
  input logic                st_req,
  input logic                cnt_pend,
  input logic [2*DATA_W-1:0] cnt_hold,
  input logic                st_pend,
  input logic [DATA_W-1:0]   st_hold,
  input logic                ptr
);
  // R4
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_pend |=> $stable(cnt_hold));

  // R2
  prog_clears_chk: assert property (@(posedge clk) disable iff (rst)
    prog_hit |=> (!cnt_pend && !st_pend && !ptr));

  // R9
  status_first_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && st_pend && !prog_hit) |=> (rd_data == $past(st_hold)));

  // R8
  status_out_chk: assert property (@(posedge clk) disable iff (rst)
    (st_req && !st_pend && !prog_hit) |=> (st_hold[DATA_W-1] == $past(out_level)));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rd_data));
endmodule

bind tmr_readback tmr_readback_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd        (rd),
  .rd_data   (rd_data),
  .out_level (out_level),
  .prog_hit  (prog_hit),
  .st_req    (st_req),
  .cnt_pend  (cnt_pend),
  .cnt_hold  (cnt_hold),
  .st_pend   (st_pend),
  .st_hold   (st_hold),
  .ptr       (ptr)
);

// File: tb/tb_tmr_readback.sv
module tb_tmr_readback;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cw_wr = 1'b0;
  logic [7:0]  cw_data = '0;
  logic        rd = 1'b0;
  logic [15:0] live;
  logic        out_level = 1'b0;
  logic        null_count = 1'b0;
  logic [7:0]  rd_data;

  int total = 0;
  int bad   = 0;
  logic rd_seen = 1'b0;
  logic [7:0] last_exp = '0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) live <= 16'h1234;
    else     live <= live - 16'h0101;
  end

  tmr_readback #(.DATA_W(8), .CHAN(1)) dut (
    .clk(clk), .rst(rst), .cw_wr(cw_wr), .cw_data(cw_data), .rd(rd),
    .live_count(live), .out_level(out_level), .null_count(null_count),
    .rd_data(rd_data)
  );

  always @(posedge clk) rd_seen <= rd;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_seen) begin
      if (q.size() == 0) begin
        check(rd_data, 8'hxx, "R12 unexpected read");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rd_data, e.v, e.tag);
      end
    end
  end

  task automatic cmd(input logic [7:0] b, output logic [15:0] snap);
    @(negedge clk);
    cw_wr = 1'b1;
    cw_data = b;
    snap = live;
    @(negedge clk);
    cw_wr = 1'b0;
  endtask

  // kind: 0 explicit value, 1 live low byte, 2 live high byte
  task automatic rd_byte(input int kind, input logic [7:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    rd = 1'b1;
    case (kind)
      1:       e.v = live[7:0];
      2:       e.v = live[15:8];
      default: e.v = v;
    endcase
    e.tag = tag;
    last_exp = e.v;
    q.push_back(e);
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] s, d;
    repeat (4) @(negedge clk);
    check(rd_data, 8'h00, "R1 reset rd_data");
    rst = 1'b0;
    rd_byte(1, 0, "R1 default low");
    rd_byte(2, 0, "R1 default high");

    cmd(8'h74, d);
    rd_byte(1, 0, "R6 live low");
    rd_byte(2, 0, "R6 live high");

    cmd(8'h40, s);
    repeat (3) @(negedge clk);
    cmd(8'h40, d);
    rd_byte(0, s[7:0], "R3 R4 latched low");
    rd_byte(0, s[15:8], "R3 R4 latched high");
    rd_byte(1, 0, "R5 released low");
    rd_byte(2, 0, "R5 released high");

    cmd(8'h40, s);
    cmd(8'h74, d);
    rd_byte(1, 0, "R2 latch dropped low");
    rd_byte(2, 0, "R2 latch dropped high");

    rd_byte(1, 0, "R6 low before reprogram");
    cmd(8'h74, d);
    rd_byte(1, 0, "R2 pointer reset low");
    rd_byte(2, 0, "R6 high after reset");

    cmd(8'h40, s);
    cmd(8'h34, d);
    cmd(8'h00, d);
    cmd(8'hE2, d);
    rd_byte(0, s[7:0], "R11 other channel low");
    rd_byte(0, s[15:8], "R11 other channel high");

    out_level = 1'b1;
    cmd(8'hE4, d);
    out_level = 1'b0;
    rd_byte(0, 8'hB4, "R8 status captured");
    rd_byte(1, 0, "R10 status released low");
    rd_byte(2, 0, "R10 status released high");

    out_level = 1'b1;
    cmd(8'hE4, d);
    out_level = 1'b0;
    cmd(8'hE4, d);
    rd_byte(0, 8'hB4, "R10 second request ignored");
    rd_byte(1, 0, "R10 then live low");
    rd_byte(2, 0, "R10 then live high");

    null_count = 1'b1;
    cmd(8'hC4, s);
    rd_byte(0, 8'h74, "R9 status first");
    rd_byte(0, s[7:0], "R9 then latched low");
    rd_byte(0, s[15:8], "R9 then latched high");
    null_count = 1'b0;

    cmd(8'hD4, s);
    rd_byte(0, s[7:0], "R7 readback count low");
    rd_byte(0, s[15:8], "R7 readback count high");
    rd_byte(1, 0, "R7 no status pending");

    cmd(8'h52, d);
    cmd(8'h40, s);
    rd_byte(0, s[7:0], "R6 low-only latched");
    rd_byte(1, 0, "R5 low-only released");
    out_level = 1'b1;
    cmd(8'hE4, d);
    rd_byte(0, 8'h92, "R8 echo of low-only word");
    out_level = 1'b0;

    cmd(8'h64, d);
    cmd(8'h40, s);
    rd_byte(0, s[15:8], "R6 high-only latched");
    rd_byte(2, 0, "R5 high-only released");

    repeat (3) @(negedge clk);
    check(rd_data, last_exp, "R12 rd_data holds");

    while (q.size() != 0) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule